// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the timing strobes for a multiplexed external memory bus on a small 8-bit controller core. It runs from the oscillator clock. A phase counter splits each machine cycle of twelve oscillator periods into two halves. It generates an address latch strobe, an active-low program-read strobe and the value driven on the upper address port. The core announces the kind of each machine cycle on `cyc_type`. The sequencer takes that value at the end of the running cycle and applies it to the whole of the next one.

During data-space accesses the latch strobe drops its second pulse and the program-read strobe drops both of its pulses. A software-controlled quiet bit can park the latch strobe high. That bit is ignored while a table or external data move is in progress, and also while the core runs from external program memory. The reset pin is qualified: only a high level that lasts two full machine cycles resets the sequencer.

Top module: `ebus_seq`

## Requirements
- R1: The block resets only when `rst_in` has been high for 24 consecutive clocks (two machine cycles). The internal reset takes effect on the clock edge that samples the 24th high level. A shorter high pulse leaves the strobe sequence running undisturbed.
- R2: While reset is active, `ale` is 0, `psen_n` is 1 and `addr_hi` is 8'hFF. The phase counter restarts at phase 0, so the first clock after release drives `ale` high.
- R3: With the quiet function inactive and outside data cycles, `ale` is high for two clocks at phases 0-1 and 6-7 of every 12-clock cycle. That is one pulse every six clocks.
- R4: In a data cycle (`cyc_type` 2 or 3), the pulse at phases 6-7 is omitted. The pulse at phases 0-1 remains.
- R5: When `ale_off` is 1, `movx_busy` is 0 and `ext_exec` is 0, `ale` is held high.
- R6: When `ext_exec` is 1, `ale_off` has no effect and `ale` pulses as in R3/R4.
- R7: When `movx_busy` is 1, `ale_off` has no effect and `ale` pulses as in R3/R4.
- R8: In an external program fetch cycle (`cyc_type` 1), `psen_n` is low at phases 3-5 and 9-11. That gives two strobes per cycle.
- R9: In internal fetch cycles (`cyc_type` 0) and data cycles (`cyc_type` 2, 3), `psen_n` stays high.
- R10: `addr_hi` carries `addr[15:8]` for `cyc_type` 1 and 2, and carries `p2_reg` for `cyc_type` 0 and 3.
- R11: `cyc_type` is sampled on the edge that ends phase 11 and governs the whole following machine cycle. All outputs are registered: each one reflects the phase, cycle type and control inputs present before the edge that updates it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Raw reset pin, active high, qualified internally |
| cyc_type | input | 2 | Kind of next machine cycle: 0 internal fetch, 1 external fetch, 2 data 16-bit pointer, 3 data 8-bit pointer |
| ale_off | input | 1 | Quiet request for the latch strobe |
| movx_busy | input | 1 | Table or external data move in progress |
| ext_exec | input | 1 | Core executes from external program memory |
| addr | input | 16 | Current bus address |
| p2_reg | input | 8 | Upper port register contents |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-read strobe, active low |
| addr_hi | output | 8 | Upper address port value |

## Verification
Each cycle type is run on its own for several cycles, so the fetch, both data-cycle strobe patterns and the pure internal pattern can be seen apart. The quiet bit is then combined with each of its two overrides, which separates an unconditional idle level from an override that is honoured. Cycle-type changes made in mid-cycle show whether the type is latched at the cycle boundary or followed at once. A short reset glitch and a long reset pulse separate a qualified reset from a plain one. A long seeded random run with mixed types, controls, addresses and reset pulses then compares every output on every clock against a reference model.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [1:0] {
    CYC_INT     = 2'd0,
    CYC_XFETCH  = 2'd1,
    CYC_XDATA16 = 2'd2,
    CYC_XDATA8  = 2'd3
  } cyc_e;
endpackage

// File: rtl/ebus_rst_qual.sv
module ebus_rst_qual #(
  parameter int LIMIT = 24
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_q
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] hi_cnt;

  // Count consecutive high samples; saturate at the limit.
  always_ff @(posedge clk) begin
    if (!rst_in) begin
      hi_cnt <= '0;
      rst_q  <= 1'b0;
    end else begin
      if (hi_cnt != LIM_C) hi_cnt <= hi_cnt + 1'b1;
      if (hi_cnt == LIM_M1) rst_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ebus_phase.sv
module ebus_phase #(
  parameter int PH_PER_CYC = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [$clog2(PH_PER_CYC)-1:0] ph,
  output logic                          wrap
);
  localparam int PW = $clog2(PH_PER_CYC);
  localparam logic [PW-1:0] LAST = PW'(PH_PER_CYC - 1);

  assign wrap = (ph == LAST);

  always_ff @(posedge clk) begin
    if (rst)       ph <= '0;
    else if (wrap) ph <= '0;
    else           ph <= ph + 1'b1;
  end
endmodule

// File: rtl/ebus_strobe.sv
module ebus_strobe
  import ebus_pkg::*;
#(
  parameter int PH_PER_CYC = 12,
  parameter int ALE_W      = 2
) (
  input  logic [$clog2(PH_PER_CYC)-1:0] ph,
  input  cyc_e                          ctype,
  input  logic                          ale_off,
  input  logic                          movx_busy,
  input  logic                          ext_exec,
  input  logic [7:0]                    hi_addr,
  input  logic [7:0]                    p2_reg,
  output logic                          ale_d,
  output logic                          psen_n_d,
  output logic [7:0]                    hi_d
);
  localparam int PW = $clog2(PH_PER_CYC);
  localparam int HALF = PH_PER_CYC / 2;
  localparam logic [PW-1:0] HALF_C  = PW'(HALF);
  localparam logic [PW-1:0] ALEW_C  = PW'(ALE_W);
  localparam logic [PW-1:0] PSTRT_C = PW'(HALF / 2);

  logic          second_half;
  logic [PW-1:0] sub;
  logic          is_data;
  logic          quiet;

  always_comb begin
    second_half = (ph >= HALF_C);
    sub         = second_half ? (ph - HALF_C) : ph;
    is_data     = (ctype == CYC_XDATA16) || (ctype == CYC_XDATA8);
    quiet       = ale_off && !movx_busy && !ext_exec;

    if (quiet) ale_d = 1'b1;
    else       ale_d = (sub < ALEW_C) && !(is_data && second_half);

    psen_n_d = !((ctype == CYC_XFETCH) && (sub >= PSTRT_C));

    case (ctype)
      CYC_XFETCH, CYC_XDATA16: hi_d = hi_addr;
      default:                 hi_d = p2_reg;
    endcase
  end
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int AW         = 16,
  parameter int PH_PER_CYC = 12,
  parameter int RST_CYCLES = 2,
  parameter int ALE_W      = 2
) (
  input  logic          clk,
  input  logic          rst_in,
  input  logic [1:0]    cyc_type,
  input  logic          ale_off,
  input  logic          movx_busy,
  input  logic          ext_exec,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    p2_reg,
  output logic          ale,
  output logic          psen_n,
  output logic [7:0]    addr_hi
);
  localparam int PW      = $clog2(PH_PER_CYC);
  localparam int RST_LIM = RST_CYCLES * PH_PER_CYC;

  logic          rst_q;
  logic [PW-1:0] ph;
  logic          wrap;
  cyc_e          ctype_q;
  logic          ale_d;
  logic          psen_n_d;
  logic [7:0]    hi_d;
  logic          unused_lo;

  assign unused_lo = ^addr[AW-9:0];

  ebus_rst_qual #(.LIMIT(RST_LIM)) u_rq (
    .clk    (clk),
    .rst_in (rst_in),
    .rst_q  (rst_q)
  );

  ebus_phase #(.PH_PER_CYC(PH_PER_CYC)) u_ph (
    .clk  (clk),
    .rst  (rst_q),
    .ph   (ph),
    .wrap (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst_q)     ctype_q <= CYC_INT;
    else if (wrap) ctype_q <= cyc_e'(cyc_type);
  end

  ebus_strobe #(.PH_PER_CYC(PH_PER_CYC), .ALE_W(ALE_W)) u_dec (
    .ph        (ph),
    .ctype     (ctype_q),
    .ale_off   (ale_off),
    .movx_busy (movx_busy),
    .ext_exec  (ext_exec),
    .hi_addr   (addr[AW-1:AW-8]),
    .p2_reg    (p2_reg),
    .ale_d     (ale_d),
    .psen_n_d  (psen_n_d),
    .hi_d      (hi_d)
  );

  always_ff @(posedge clk) begin
    if (rst_q) begin
      ale     <= 1'b0;
      psen_n  <= 1'b1;
      addr_hi <= 8'hFF;
    end else begin
      ale     <= ale_d;
      psen_n  <= psen_n_d;
      addr_hi <= hi_d;
    end
  end
endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
  parameter int PH_PER_CYC = 12
) (
  input logic                          clk,
  input logic                          rst_q,
  input logic [$clog2(PH_PER_CYC)-1:0] ph,
  input logic [1:0]                    ctype_q,
  input logic                          ale_off,
  input logic                          movx_busy,
  input logic                          ext_exec,
  input logic                          ale,
  input logic                          psen_n,
  input logic [7:0]                    addr_hi
);
  localparam int PW = $clog2(PH_PER_CYC);
  localparam logic [PW-1:0] HALF_C = PW'(PH_PER_CYC / 2);

  logic seen;
  initial seen = 1'b0;
  always @(posedge clk) if (rst_q) seen <= 1'b1;

  // R2
  reset_out_chk: assert property (@(posedge clk)
    (seen && $past(rst_q)) |-> (!ale && psen_n && addr_hi == 8'hFF));

  // R9
  psen_idle_chk: assert property (@(posedge clk) disable iff (rst_q || !seen)
    (ctype_q != 2'd1) |=> psen_n);

  // R8
  psen_width_chk: assert property (@(posedge clk) disable iff (rst_q || !seen)
    $fell(psen_n) |=> !psen_n);

  // R5
  ale_idle_chk: assert property (@(posedge clk) disable iff (rst_q || !seen)
    (ale_off && !movx_busy && !ext_exec) |=> ale);

  // R4
  data_skip_chk: assert property (@(posedge clk) disable iff (rst_q || !seen)
    (ctype_q[1] && ph >= HALF_C && !(ale_off && !movx_busy && !ext_exec)) |=> !ale);
endmodule

bind ebus_seq ebus_seq_chk #(.PH_PER_CYC(PH_PER_CYC)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .ph        (ph),
  .ctype_q   (ctype_q),
  .ale_off   (ale_off),
  .movx_busy (movx_busy),
  .ext_exec  (ext_exec),
  .ale       (ale),
  .psen_n    (psen_n),
  .addr_hi   (addr_hi)
);

// File: tb/ebus_seq_bench.sv
`timescale 1ns/1ps
module ebus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_in = 1'b1;
  logic [1:0]  cyc_type = 2'd0;
  logic        ale_off = 1'b0;
  logic        movx_busy = 1'b0;
  logic        ext_exec = 1'b0;
  logic [15:0] addr = 16'h1234;
  logic [7:0]  p2_reg = 8'hA5;
  logic        ale;
  logic        psen_n;
  logic [7:0]  addr_hi;

  always #2 clk = ~clk;

  ebus_seq u_ebus_seq (
    .clk(clk), .rst_in(rst_in), .cyc_type(cyc_type), .ale_off(ale_off),
    .movx_busy(movx_busy), .ext_exec(ext_exec), .addr(addr), .p2_reg(p2_reg),
    .ale(ale), .psen_n(psen_n), .addr_hi(addr_hi)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    armed = 1'b0;
  string ctx = "";

  // Reference model state
  int m_cnt = 0;
  int m_ph = 0;
  int m_ct = 0;
  bit m_rq = 1'b0;

  function automatic bit exp_ale(int ph, int ct, bit off, bit mv, bit ex);
    if (off && !mv && !ex) return 1'b1;
    return ((ph % 6) < 2) && !((ct >= 2) && (ph >= 6));
  endfunction

  function automatic bit exp_psen(int ph, int ct);
    return !((ct == 1) && ((ph % 6) >= 3));
  endfunction

  function automatic logic [7:0] exp_hi(int ct, logic [15:0] a, logic [7:0] p2);
    return (ct == 1 || ct == 2) ? a[15:8] : p2;
  endfunction

  function automatic string ale_tag(int ph, int ct, bit off, bit mv, bit ex);
    if (off && !mv && !ex) return "R5";
    if (off && ex)         return "R6";
    if (off && mv)         return "R7";
    if (ct >= 2 && ph >= 6) return "R4";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    bit         e_ale, e_psen, pre_rq, nq;
    logic [7:0] e_hi;
    string      ta, tp, th;
    @(posedge clk);
    pre_rq = m_rq;
    if (m_rq) begin
      e_ale = 1'b0; e_psen = 1'b1; e_hi = 8'hFF;
      ta = "R2"; tp = "R2"; th = "R2";
      m_ph = 0; m_ct = 0;
    end else begin
      e_ale  = exp_ale(m_ph, m_ct, ale_off, movx_busy, ext_exec);
      e_psen = exp_psen(m_ph, m_ct);
      e_hi   = exp_hi(m_ct, addr, p2_reg);
      ta = ale_tag(m_ph, m_ct, ale_off, movx_busy, ext_exec);
      tp = (m_ct == 1) ? "R8" : "R9";
      th = "R10";
      if (m_ph == 11) m_ct = int'(cyc_type);   // R11 boundary capture
      m_ph = (m_ph + 1) % 12;
    end
    // R1 qualifier model
    if (!rst_in) begin
      m_cnt = 0; nq = 1'b0;
    end else begin
      nq = m_rq || (m_cnt == 23);
      if (m_cnt != 24) m_cnt++;
    end
    m_rq = nq;
    if (pre_rq) armed = 1'b1;
    #1;
    if (armed) begin
      if (ctx != "") begin ta = ctx; tp = ctx; th = ctx; end
      chk(ta, {7'd0, ale}, {7'd0, e_ale}, "ale");
      chk(tp, {7'd0, psen_n}, {7'd0, e_psen}, "psen_n");
      chk(th, addr_hi, e_hi, "addr_hi");
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R2: long pin reset, then release
    run(30);
    rst_in = 1'b0;
    run(12);
    // R3 R8 R9 R10 R4: each cycle type alone
    for (int t = 0; t < 4; t++) begin
      cyc_type = t[1:0];
      addr = 16'h1234 + 16'(t * 16'h1111);
      p2_reg = 8'h5A ^ 8'(t);
      run(36);
    end
    // R5: quiet bit honoured
    ale_off = 1'b1;
    cyc_type = 2'd1; run(24);
    cyc_type = 2'd2; run(24);
    // R6: external execution overrides
    ext_exec = 1'b1; run(24);
    ext_exec = 1'b0;
    // R7: move in progress overrides
    movx_busy = 1'b1; cyc_type = 2'd3; run(24);
    movx_busy = 1'b0; ale_off = 1'b0;
    // R11: type changed mid-cycle must wait for the boundary
    ctx = "R11";
    cyc_type = 2'd0; run(12);
    while (m_ph != 4) tick();
    cyc_type = 2'd1; run(3);
    cyc_type = 2'd2; run(20);
    while (m_ph != 11) tick();
    cyc_type = 2'd1; run(14);
    // R1: short glitch must not reset
    ctx = "R1";
    rst_in = 1'b1; run(10);
    rst_in = 1'b0; run(24);
    rst_in = 1'b1; run(23);
    rst_in = 1'b0; run(24);
    // R2: qualified reset then restart at phase 0
    ctx = "";
    rst_in = 1'b1; run(26);
    rst_in = 1'b0; run(24);
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 5 == 0) cyc_type = 2'($urandom);
      if ($urandom % 7 == 0) addr = 16'($urandom);
      if ($urandom % 7 == 0) p2_reg = 8'($urandom);
      if ($urandom % 11 == 0) ale_off = ($urandom % 3 == 0);
      if ($urandom % 11 == 0) movx_busy = ($urandom % 4 == 0);
      if ($urandom % 13 == 0) ext_exec = ($urandom % 4 == 0);
      if ($urandom % 400 == 0) begin
        rst_in = 1'b1;
        run(5 + int'($urandom % 30));
        rst_in = 1'b0;
      end
      tick();
    end
    done = 1'b1;
    finish_up();
  end
endmodule